// File: doc/BRIEF.md
# Tone-Disable Event Interrupt Queue

This block sits beside a bank of echo-canceller channels and tells a host processor when any channel's tone-disable flag changes. Every channel gives one event when its flag goes active and a second, separate event when the flag clears. Each event passes through a per-channel mask for that edge. An event that survives its mask is queued as the channel's number in a first-in first-out store.

An active-low interrupt line is driven low while the queue holds entries and the global interrupt mask is clear. The host reads the queue register to get the channel number of the oldest event. It can then read that channel's status register, which holds the current tone-disable level, to learn whether the flag was set or cleared. After every queue read the interrupt line goes high for at least one clock. It falls again if entries remain, so each pending entry produces its own falling edge.

When several channels have events at the same time, they are queued one per clock in ascending channel order. A full queue drops new events and sets a sticky overflow flag.

Top module: `tdi_irq_fifo_ctrl`

## Requirements
- R1: A low-to-high transition on `td_in[c]` queues the value c when bit 4 of channel c's control register (address 0x40+c) is clear.
- R2: A high-to-low transition on `td_in[c]` queues the value c when bit 3 of channel c's control register is clear.
- R3: When a transition happens while its mask bit (bit 4 for rising, bit 3 for falling) is set, the event is discarded. Clearing the mask later does not bring it back. Both mask bits read back at the same positions.
- R4: Events that are detected in the same cycle are queued in ascending channel order. Each later entry is queued one clock after the previous one.
- R5: A read of address 0x01 removes the oldest entry. The channel number appears in `host_rdata[4:0]` with all upper bits zero, one clock after `host_rd`, and `host_rvalid` is high in that same clock.
- R6: A read of address 0x01 while the queue is empty returns 0xFFFF and leaves `irq_n` unchanged.
- R7: `irq_n` is low only while the queue holds at least one entry and the global mask is clear. It is high when the queue is empty.
- R8: In the clock after any read that removes an entry, `irq_n` is high. If entries remain, it goes low again one clock later.
- R9: Bit 5 of the global control register (address 0x00) holds `irq_n` high while it is set. Events are still queued during that time and can be read.
- R10: While the queue holds 32 entries, a new event is dropped and bit 0 of address 0x02 becomes 1. That bit stays set until the host writes 1 to bit 0 of address 0x02.
- R11: Bit 0 of channel c's status register (address 0x80+c) reads back the current tone-disable level of channel c.
- R12: After reset, `irq_n` is high, the queue is empty, all masks are clear and the overflow flag reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| td_in | input | NUM_CH | Tone-disable level of each channel |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 8 | Register address |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, valid one clock after `host_rd` |
| host_rvalid | output | 1 | High in the clock in which `host_rdata` is valid |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions assume that `host_rd` and `host_wr` are never high in the same clock. They also assume that `td_in` is already synchronous to `clk`, so each level the block registers is one the source really presented. The bench drives every input on the falling clock edge and issues one host access at a time. It changes tone-disable levels only while no host access is in flight, and it holds each level for several clocks so that every transition is seen as a single edge.

// File: rtl/tdi_pkg.sv
package tdi_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] A_GLOBAL = 8'h00;
  localparam logic [ADDR_W-1:0] A_FIFO   = 8'h01;
  localparam logic [ADDR_W-1:0] A_OVF    = 8'h02;

  localparam logic [1:0] REGION_CTRL = 2'b01;
  localparam logic [1:0] REGION_STAT = 2'b10;

  localparam int GMASK_BIT = 5;
  localparam int MRISE_BIT = 4;
  localparam int MFALL_BIT = 3;
  localparam int TD_BIT    = 0;
  localparam int OVF_BIT   = 0;

  localparam logic [DATA_W-1:0] EMPTY_CODE = '1;
endpackage

// File: rtl/tdi_event_bank.sv
module tdi_event_bank #(
  parameter int NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] td_in,
  input  logic [NUM_CH-1:0] msk_rise,
  input  logic [NUM_CH-1:0] msk_fall,
  input  logic [NUM_CH-1:0] clr_rise,
  input  logic [NUM_CH-1:0] clr_fall,
  output logic [NUM_CH-1:0] td_now,
  output logic [NUM_CH-1:0] rise_p,
  output logic [NUM_CH-1:0] fall_p
);

  logic [NUM_CH-1:0] td_q;
  logic [NUM_CH-1:0] td_prev;

  assign td_now = td_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic up_edge;
    logic dn_edge;

    assign up_edge = td_q[g] & ~td_prev[g];
    assign dn_edge = ~td_q[g] & td_prev[g];

    always_ff @(posedge clk) begin
      if (rst) begin
        td_q[g]    <= 1'b0;
        td_prev[g] <= 1'b0;
        rise_p[g]  <= 1'b0;
        fall_p[g]  <= 1'b0;
      end else begin
        td_q[g]    <= td_in[g];
        td_prev[g] <= td_q[g];
        // a new edge wins over a grant in the same cycle
        rise_p[g]  <= (rise_p[g] & ~clr_rise[g]) | (up_edge & ~msk_rise[g]);
        fall_p[g]  <= (fall_p[g] & ~clr_fall[g]) | (dn_edge & ~msk_fall[g]);
      end
    end

    AST_RISE_HELD: assert property (@(posedge clk) disable iff (rst)
      rise_p[g] && !clr_rise[g] |=> rise_p[g]); // R1
    AST_FALL_HELD: assert property (@(posedge clk) disable iff (rst)
      fall_p[g] && !clr_fall[g] |=> fall_p[g]); // R2
    AST_MASKED_RISE: assert property (@(posedge clk) disable iff (rst)
      !rise_p[g] && msk_rise[g] |=> !rise_p[g]); // R3
    AST_MASKED_FALL: assert property (@(posedge clk) disable iff (rst)
      !fall_p[g] && msk_fall[g] |=> !fall_p[g]); // R3
  end

endmodule

// File: rtl/tdi_arbiter.sv
module tdi_arbiter #(
  parameter int NUM_CH = 32,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] rise_p,
  input  logic [NUM_CH-1:0] fall_p,
  output logic              gnt_valid,
  output logic [CH_W-1:0]   gnt_ch,
  output logic [NUM_CH-1:0] clr_rise,
  output logic [NUM_CH-1:0] clr_fall
);

  logic [NUM_CH-1:0] any_p;
  assign any_p = rise_p | fall_p;

  // lowest channel number wins
  always_comb begin
    gnt_valid = 1'b0;
    gnt_ch    = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (any_p[i]) begin
        gnt_valid = 1'b1;
        gnt_ch    = CH_W'(i);
      end
    end
  end

  // one bit consumed per grant; rising edge served before falling
  always_comb begin
    clr_rise = '0;
    clr_fall = '0;
    if (gnt_valid) begin
      if (rise_p[gnt_ch]) clr_rise[gnt_ch] = 1'b1;
      else                clr_fall[gnt_ch] = 1'b1;
    end
  end

  AST_GRANT_SERVES_PENDING: assert property (@(posedge clk) disable iff (rst)
    (any_p != '0) |-> gnt_valid); // R4
  AST_SINGLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $countones({clr_rise, clr_fall}) <= 1); // R4

endmodule

// File: rtl/tdi_fifo.sv
module tdi_fifo #(
  parameter int WIDTH = 5,
  parameter int DEPTH = 32,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);

  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    rd_ptr;
  logic [CW-1:0]    count;

  assign full  = (count == DEPTH_C);
  assign empty = (count == '0);

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (pop) dout <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> !full); // R10
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty); // R6
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= DEPTH_C); // R10

endmodule

// File: rtl/tdi_irq_gen.sv
module tdi_irq_gen (
  input  logic clk,
  input  logic rst,
  input  logic have_entry,
  input  logic gmask,
  input  logic pop,
  output logic irq_n
);

  // a removing read forces one high clock before the next fall
  always_ff @(posedge clk) begin
    if (rst)      irq_n <= 1'b1;
    else if (pop) irq_n <= 1'b1;
    else          irq_n <= ~(have_entry & ~gmask);
  end

  AST_IRQ_GAP: assert property (@(posedge clk) disable iff (rst)
    pop |=> irq_n); // R8
  AST_GMASK_QUIET: assert property (@(posedge clk) disable iff (rst)
    gmask |=> irq_n); // R9
  AST_IRQ_REFIRE: assert property (@(posedge clk) disable iff (rst)
    have_entry && !gmask && !pop |=> !irq_n); // R7

endmodule

// File: rtl/tdi_irq_fifo_ctrl.sv
module tdi_irq_fifo_ctrl
  import tdi_pkg::*;
#(
  parameter int NUM_CH     = 32,
  parameter int FIFO_DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] td_in,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic              irq_n
);

  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int OFS_W = ADDR_W - 2;

  // ---------------- address decode ----------------
  logic [1:0]       region;
  logic [OFS_W-1:0] offs;
  logic [CH_W-1:0]  idx;
  logic             idx_ok;
  logic             sel_glob, sel_fifo, sel_ovf, ctrl_hit, stat_hit;

  assign region   = host_addr[ADDR_W-1 -: 2];
  assign offs     = host_addr[OFS_W-1:0];
  assign idx      = offs[CH_W-1:0];
  assign idx_ok   = int'(offs) < NUM_CH;
  assign sel_glob = (host_addr == A_GLOBAL);
  assign sel_fifo = (host_addr == A_FIFO);
  assign sel_ovf  = (host_addr == A_OVF);
  assign ctrl_hit = (region == REGION_CTRL) && idx_ok;
  assign stat_hit = (region == REGION_STAT) && idx_ok;

  // ---------------- control state ----------------
  logic              gmask;
  logic [NUM_CH-1:0] msk_rise;
  logic [NUM_CH-1:0] msk_fall;
  logic              ovf_q;
  logic              ovf_set;
  logic              ovf_clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      gmask    <= 1'b0;
      msk_rise <= '0;
      msk_fall <= '0;
    end else if (host_wr) begin
      if (sel_glob) gmask <= host_wdata[GMASK_BIT];
      if (ctrl_hit) begin
        msk_rise[idx] <= host_wdata[MRISE_BIT];
        msk_fall[idx] <= host_wdata[MFALL_BIT];
      end
    end
  end

  assign ovf_clr = host_wr && sel_ovf && host_wdata[OVF_BIT];

  always_ff @(posedge clk) begin
    if (rst)          ovf_q <= 1'b0;
    else if (ovf_set) ovf_q <= 1'b1;
    else if (ovf_clr) ovf_q <= 1'b0;
  end

  // ---------------- event path ----------------
  logic [NUM_CH-1:0] td_now, rise_p, fall_p, clr_rise, clr_fall;
  logic              gnt_valid;
  logic [CH_W-1:0]   gnt_ch;

  tdi_event_bank #(.NUM_CH(NUM_CH)) u_events (
    .clk      (clk),
    .rst      (rst),
    .td_in    (td_in),
    .msk_rise (msk_rise),
    .msk_fall (msk_fall),
    .clr_rise (clr_rise),
    .clr_fall (clr_fall),
    .td_now   (td_now),
    .rise_p   (rise_p),
    .fall_p   (fall_p)
  );

  tdi_arbiter #(.NUM_CH(NUM_CH)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .rise_p    (rise_p),
    .fall_p    (fall_p),
    .gnt_valid (gnt_valid),
    .gnt_ch    (gnt_ch),
    .clr_rise  (clr_rise),
    .clr_fall  (clr_fall)
  );

  // ---------------- queue ----------------
  logic            fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic [CH_W-1:0] fifo_dout;

  assign fifo_push = gnt_valid && !fifo_full;
  assign ovf_set   = gnt_valid && fifo_full;
  assign fifo_pop  = host_rd && sel_fifo && !fifo_empty;

  tdi_fifo #(.WIDTH(CH_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (fifo_push),
    .din   (gnt_ch),
    .pop   (fifo_pop),
    .dout  (fifo_dout),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  tdi_irq_gen u_irq (
    .clk        (clk),
    .rst        (rst),
    .have_entry (!fifo_empty),
    .gmask      (gmask),
    .pop        (fifo_pop),
    .irq_n      (irq_n)
  );

  // ---------------- read path ----------------
  logic [DATA_W-1:0] reg_val;
  logic [DATA_W-1:0] reg_q;
  logic              rd_from_fifo;

  always_comb begin
    reg_val = '0;
    if (sel_glob)      reg_val[GMASK_BIT] = gmask;
    else if (sel_ovf)  reg_val[OVF_BIT]   = ovf_q;
    else if (sel_fifo) reg_val            = EMPTY_CODE;
    else if (ctrl_hit) begin
      reg_val[MRISE_BIT] = msk_rise[idx];
      reg_val[MFALL_BIT] = msk_fall[idx];
    end else if (stat_hit) begin
      reg_val[TD_BIT] = td_now[idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rvalid  <= 1'b0;
      rd_from_fifo <= 1'b0;
      reg_q        <= '0;
    end else begin
      host_rvalid <= host_rd;
      if (host_rd) begin
        rd_from_fifo <= fifo_pop;
        reg_q        <= reg_val;
      end
    end
  end

  assign host_rdata = rd_from_fifo ? DATA_W'(fifo_dout) : reg_q;

  AST_IRQ_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> !fifo_empty); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf_q && !ovf_clr |=> ovf_q); // R10
  AST_EMPTY_READ_CODE: assert property (@(posedge clk) disable iff (rst)
    host_rd && sel_fifo && fifo_empty |=> host_rdata == EMPTY_CODE); // R6
  AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    host_rd |=> host_rvalid); // R5
  AST_ACCESS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(host_rd && host_wr)); // R5

endmodule

// File: tb/tdi_irq_fifo_ctrl_test.sv
`timescale 1ns/1ps
module tdi_irq_fifo_ctrl_test;
  import tdi_pkg::*;

  localparam int NCH = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NCH-1:0]    td_drv = '0;
  logic              host_wr = 1'b0;
  logic              host_rd = 1'b0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [DATA_W-1:0] host_wdata = '0;
  logic [DATA_W-1:0] host_rdata;
  logic              host_rvalid;
  logic              irq_n;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  tdi_irq_fifo_ctrl #(.NUM_CH(NCH), .FIFO_DEPTH(32)) uut (
    .clk        (clk),
    .rst        (rst),
    .td_in      (td_drv),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .host_rvalid(host_rvalid),
    .irq_n      (irq_n)
  );

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
    chk_eq("R5 rvalid", 32'(host_rvalid), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] d;
    idle(4);
    rst = 1'b0;
    idle(2);

    // R12 reset state
    chk_eq("R12 irq after reset", 32'(irq_n), 32'd1);
    rd(A_OVF, d);        chk_eq("R12 overflow clear", 32'(d), 32'd0);
    rd(8'h45, d);        chk_eq("R12 masks clear", 32'(d), 32'd0);
    rd(A_GLOBAL, d);     chk_eq("R12 global mask clear", 32'(d), 32'd0);
    rd(A_FIFO, d);       chk_eq("R6 empty code", 32'(d), 32'hFFFF);
    chk_eq("R6 irq unchanged by empty read", 32'(irq_n), 32'd1);

    // R1 R2 R11 sweep over every channel
    for (int ch = 0; ch < NCH; ch++) begin
      td_drv[ch] = 1'b1;
      idle(6);
      chk_eq("R7 irq low with entry", 32'(irq_n), 32'd0);
      rd(8'(8'h80 + ch), d); chk_eq("R11 status high", 32'(d), 32'd1);
      rd(A_FIFO, d);         chk_eq("R1 rising channel", 32'(d), 32'(ch));
      chk_eq("R8 irq high after read", 32'(irq_n), 32'd1);
      idle(2);
      chk_eq("R7 irq high when empty", 32'(irq_n), 32'd1);
      td_drv[ch] = 1'b0;
      idle(6);
      rd(A_FIFO, d);         chk_eq("R2 falling channel", 32'(d), 32'(ch));
      rd(8'(8'h80 + ch), d); chk_eq("R11 status low", 32'(d), 32'd0);
    end

    // R8 re-pulse with two entries
    td_drv[3] = 1'b1; td_drv[7] = 1'b1;
    idle(8);
    chk_eq("R7 irq low two entries", 32'(irq_n), 32'd0);
    rd(A_FIFO, d);  chk_eq("R4 lower channel first", 32'(d), 32'd3);
    chk_eq("R8 gap high", 32'(irq_n), 32'd1);
    idle(1);
    chk_eq("R8 re-asserts", 32'(irq_n), 32'd0);
    rd(A_FIFO, d);  chk_eq("R4 second channel", 32'(d), 32'd7);
    chk_eq("R8 gap high last", 32'(irq_n), 32'd1);
    idle(2);
    chk_eq("R7 stays high empty", 32'(irq_n), 32'd1);
    td_drv[3] = 1'b0; td_drv[7] = 1'b0;
    idle(8);
    rd(A_FIFO, d);  chk_eq("R2 fall ch3", 32'(d), 32'd3);
    rd(A_FIFO, d);  chk_eq("R2 fall ch7", 32'(d), 32'd7);

    // R3 per-channel masks: even channels mask rise, odd mask fall
    for (int ch = 0; ch < NCH; ch++)
      wr(8'(8'h40 + ch), (ch % 2 == 0) ? 16'h0010 : 16'h0008);
    rd(8'h40, d); chk_eq("R3 rise mask readback", 32'(d), 32'h10);
    rd(8'h41, d); chk_eq("R3 fall mask readback", 32'(d), 32'h08);
    td_drv = '1;
    idle(40);
    for (int ch = 1; ch < NCH; ch += 2) begin
      rd(A_FIFO, d); chk_eq("R3 unmasked rise only", 32'(d), 32'(ch));
    end
    rd(A_FIFO, d); chk_eq("R3 masked rises dropped", 32'(d), 32'hFFFF);
    td_drv = '0;
    idle(40);
    for (int ch = 0; ch < NCH; ch += 2) begin
      rd(A_FIFO, d); chk_eq("R3 unmasked fall only", 32'(d), 32'(ch));
    end
    for (int ch = 0; ch < NCH; ch++) wr(8'(8'h40 + ch), 16'h0000);
    idle(8);
    rd(A_FIFO, d); chk_eq("R3 no stale after unmask", 32'(d), 32'hFFFF);

    // R9 global mask
    wr(A_GLOBAL, 16'h0020);
    rd(A_GLOBAL, d); chk_eq("R9 mask readback", 32'(d), 32'h20);
    td_drv[5] = 1'b1;
    idle(8);
    chk_eq("R9 irq held high", 32'(irq_n), 32'd1);
    rd(A_FIFO, d); chk_eq("R9 still queued", 32'(d), 32'd5);
    wr(A_GLOBAL, 16'h0000);
    td_drv[5] = 1'b0;
    idle(8);
    chk_eq("R9 irq after unmask", 32'(irq_n), 32'd0);
    rd(A_FIFO, d); chk_eq("R2 fall after unmask", 32'(d), 32'd5);

    // R10 overflow with a full queue
    td_drv = '1;
    idle(45);
    td_drv[0] = 1'b0;
    idle(10);
    rd(A_OVF, d); chk_eq("R10 overflow set", 32'(d), 32'd1);
    for (int ch = 0; ch < NCH; ch++) begin
      rd(A_FIFO, d); chk_eq("R4 ascending fill", 32'(d), 32'(ch));
    end
    rd(A_FIFO, d); chk_eq("R10 dropped event absent", 32'(d), 32'hFFFF);
    rd(A_OVF, d);  chk_eq("R10 overflow sticky", 32'(d), 32'd1);
    wr(A_OVF, 16'h0001);
    rd(A_OVF, d);  chk_eq("R10 overflow cleared", 32'(d), 32'd0);
    td_drv = '0;
    idle(40);
    for (int ch = 1; ch < NCH; ch++) begin
      rd(A_FIFO, d); chk_eq("R4 ascending falls", 32'(d), 32'(ch));
    end
    rd(A_FIFO, d); chk_eq("R6 drained", 32'(d), 32'hFFFF);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule